// File: doc/BRIEF.md
# Two-Wire Command/Response Slave

This block is a serial slave for a two-wire bus made of a clock line and an open-drain data line. A host uses it to hand commands to a core and to collect the core's replies. A fast system clock oversamples both lines. The block finds start and stop conditions and compares the first byte of each transaction against its device address.

A write fills a fixed command buffer. Byte 0 is the command and up to seven argument bytes follow. At the stop, the block tells the core with a one-cycle pulse. A read always streams the response buffer from byte 0. Byte 0 is a status byte, and its top bit tells the host whether a new command may be sent. The block has no register pointer, so every read begins at the same place.

The core answers through a flat response vector and a one-cycle `rsp_ready` pulse. The block's ready flag drops when a command is handed over and rises again when `rsp_ready` pulses.

Top module: `cmdrsp_slave`

## Requirements
- R1: A start condition (data falling while clock is high) opens a transaction. A stop condition (data rising while clock is high) closes it. Any command pulse happens only after the stop.
- R2: The first byte after a start is a control byte, sent MSB first and sampled on clock rising edges. Bits 7:1 are the address and bit 0 is the direction (1 = read, 0 = write). The address is ADDR_A when `addr_sel` is 0 and ADDR_B when it is 1. On a match, the slave pulls data low for the ninth bit. On a mismatch it never drives the line until the next start.
- R3: On a write, each of the first CMD_BYTES data bytes is acknowledged and stored. Byte k appears on `cmd_data[8k+7:8k]`. Later bytes get no acknowledge and leave `cmd_data` unchanged.
- R4: At a stop, `cmd_valid` pulses high for exactly one cycle if at least one data byte was stored, and `cmd_len` then holds the stored count. A write transaction with no data bytes, or one with no address match, gives no pulse.
- R5: A read returns byte 0 first, then bytes 1, 2 and onward from `rsp_data` (byte i is `rsp_data[8i+7:8i]`), MSB first. Byte 0 is sent as {ready & rsp_data[7], rsp_data[6:0]}.
- R6: Read bytes at index RSP_BYTES and above return 0xFF.
- R7: When the master does not acknowledge a read byte, the slave releases the data line and keeps it released until the next start.
- R8: The ready output `cts` is 1 after reset. It goes to 0 in the cycle after `cmd_valid` and returns to 1 the cycle after a `rsp_ready` pulse.
- R9: The slave changes `sda_oe` only while the synchronised clock is low.
- R10: After reset, `sda_oe` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| addr_sel | input | 1 | Chooses between the two device addresses |
| rsp_ready | input | 1 | Core pulse: the response is ready |
| rsp_data | input | RSP_BYTES*8 | Response bytes, byte i at [8i+7:8i] |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| cmd_valid | output | 1 | One-cycle pulse: a command is ready |
| cmd_data | output | CMD_BYTES*8 | Command buffer, byte k at [8k+7:8k] |
| cmd_len | output | LEN_W | Number of stored bytes in the last command |
| cts | output | 1 | Ready for a new command |

## Verification
A bit counter that is off by one moves the acknowledge slot. The host then sees a missing or misplaced acknowledge on the same byte, within one bit period. A wrong write index shows as a shifted or corrupted `cmd_data` byte, or a wrong `cmd_len`, at the first pulse after the stop. A wrong read index or a bad saturation point shows as a wrong byte value at the exact byte position where it occurs, for example a 0xFF appearing early, or a real data byte appearing at index 16. A state machine that fails to leave its ignore state shows as a missing acknowledge on the next transaction.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_IGN
  } cr_state_t;

  function automatic logic [6:0] pick_addr(input logic sel, input logic [6:0] a, input logic [6:0] b);
    return sel ? b : a;
  endfunction
endpackage

// File: rtl/cmdrsp_sync.sv
module cmdrsp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/cmdrsp_cond.sv
module cmdrsp_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cmdrsp_slave.sv
module cmdrsp_slave
  import cmdrsp_pkg::*;
#(
  parameter logic [6:0] ADDR_A = 7'h11,
  parameter logic [6:0] ADDR_B = 7'h63,
  parameter int CMD_BYTES = 8,
  parameter int RSP_BYTES = 16,
  localparam int LEN_W = $clog2(CMD_BYTES + 1),
  localparam int IDX_W = $clog2(RSP_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  input  logic                   addr_sel,
  input  logic                   rsp_ready,
  input  logic [RSP_BYTES*8-1:0] rsp_data,
  output logic                   sda_oe,
  output logic                   cmd_valid,
  output logic [CMD_BYTES*8-1:0] cmd_data,
  output logic [LEN_W-1:0]       cmd_len,
  output logic                   cts
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  cmdrsp_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
  );

  cmdrsp_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  cr_state_t              state;
  logic [3:0]             bitc;
  logic [7:0]             sh, tx;
  logic                   rw, ack_ok, oe_q, valid_q, cts_q;
  logic [LEN_W-1:0]       wr_cnt, len_q;
  logic [IDX_W-1:0]       rd_idx;
  logic [CMD_BYTES*8-1:0] cbuf;
  logic [7:0]             nxt_byte;
  logic                   addr_hit, byte_in_done, wr_room;

  function automatic logic [7:0] rsp_pick(input logic [IDX_W-1:0] idx, input logic rdy,
                                          input logic [RSP_BYTES*8-1:0] rd);
    if (int'(idx) >= RSP_BYTES) return 8'hFF;
    if (idx == '0)              return {rdy & rd[7], rd[6:0]};
    return rd[int'(idx)*8 +: 8];
  endfunction

  assign nxt_byte     = rsp_pick(rd_idx, cts_q, rsp_data);
  assign addr_hit     = (sh[7:1] == pick_addr(addr_sel, ADDR_A, ADDR_B));
  assign byte_in_done = scl_fall && (bitc == 4'd8);
  assign wr_room      = (int'(wr_cnt) < CMD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitc    <= '0;
      sh      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      ack_ok  <= 1'b0;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      wr_cnt  <= '0;
      len_q   <= '0;
      rd_idx  <= '0;
      cbuf    <= '0;
    end else begin
      valid_q <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        bitc   <= '0;
        oe_q   <= 1'b0;
        wr_cnt <= '0;
        rd_idx <= '0;
      end else if (stop_ev) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
        if (wr_cnt != '0) begin
          valid_q <= 1'b1;
          len_q   <= wr_cnt;
          wr_cnt  <= '0;
        end
      end else begin
        unique case (state)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_s};
              bitc <= bitc + 4'd1;
            end
            if (byte_in_done) begin
              bitc <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  oe_q  <= 1'b1;
                  rw    <= sh[0];
                  state <= ST_AACK;
                end else begin
                  state <= ST_IGN;
                end
              end else begin
                if (wr_room) begin
                  cbuf[int'(wr_cnt)*8 +: 8] <= sh;
                  wr_cnt <= wr_cnt + 1'b1;
                  oe_q   <= 1'b1;
                end
                state <= ST_WACK;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            oe_q <= 1'b0;
            bitc <= '0;
            if (rw) begin
              tx     <= {nxt_byte[6:0], 1'b0};
              oe_q   <= ~nxt_byte[7];
              rd_idx <= rd_idx + 1'b1;
              state  <= ST_RDAT;
            end else begin
              state <= ST_WDAT;
            end
          end
          ST_WACK: if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_WDAT;
          end
          ST_RDAT: begin
            if (scl_rise) bitc <= bitc + 4'd1;
            if (scl_fall) begin
              if (bitc == 4'd8) begin
                oe_q  <= 1'b0;
                bitc  <= '0;
                state <= ST_RACK;
              end else begin
                oe_q <= ~tx[7];
                tx   <= {tx[6:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) ack_ok <= ~sda_s;
            if (scl_fall) begin
              if (ack_ok) begin
                tx    <= {nxt_byte[6:0], 1'b0};
                oe_q  <= ~nxt_byte[7];
                if (int'(rd_idx) < RSP_BYTES) rd_idx <= rd_idx + 1'b1;
                state <= ST_RDAT;
              end else begin
                state <= ST_IGN;
              end
            end
          end
          default: oe_q <= 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cts_q <= 1'b1;
    else if (valid_q)   cts_q <= 1'b0;
    else if (rsp_ready) cts_q <= 1'b1;
  end

  assign sda_oe    = oe_q;
  assign cmd_valid = valid_q;
  assign cmd_data  = cbuf;
  assign cmd_len   = len_q;
  assign cts       = cts_q;
endmodule

// File: rtl/cmdrsp_chk.sv
module cmdrsp_chk #(
  parameter int CMD_BYTES = 8,
  parameter int LEN_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_ev,
  input logic             stop_ev,
  input logic             sda_oe,
  input logic             cmd_valid,
  input logic             cts,
  input logic             rsp_ready,
  input logic [LEN_W-1:0] cmd_len
);
  a_r1_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(stop_ev));
  a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r4_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != '0 && int'(cmd_len) <= CMD_BYTES));
  a_r8_cts_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cts);
  a_r8_cts_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts) |-> $past(rsp_ready));
  a_r9_oe_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
endmodule

bind cmdrsp_slave cmdrsp_chk #(.CMD_BYTES(CMD_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev), .stop_ev(stop_ev),
  .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cts(cts), .rsp_ready(rsp_ready), .cmd_len(cmd_len)
);

// File: tb/sim_cmdrsp_slave.sv
module sim_cmdrsp_slave;
  localparam int H = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda_low = 1'b0, addr_sel = 1'b0, rsp_ready = 1'b0;
  logic [127:0] rsp_data;
  logic sda_in, sda_oe, cmd_valid, cts;
  logic [63:0] cmd_data;
  logic [3:0] cmd_len;
  int n_chk = 0, n_fail = 0, pulses = 0, viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] wbuf [0:11];

  always #5 clk = ~clk;
  assign sda_in = ~(m_sda_low | sda_oe);

  cmdrsp_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_in), .addr_sel(addr_sel),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_len(cmd_len), .cts(cts)
  );

  always @(negedge clk) begin
    if (cmd_valid) pulses++;
    if (sda_oe !== prev_oe && m_scl) viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hp(); repeat (H) @(negedge clk); endtask

  task automatic bus_start();
    m_sda_low = 0; m_scl = 1; hp(); m_sda_low = 1; hp(); m_scl = 0; @(negedge clk);
  endtask

  task automatic bus_stop();
    m_sda_low = 1; hp(); m_scl = 1; hp(); m_sda_low = 0; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; hp(); m_scl = 1; hp(); m_scl = 0; @(negedge clk);
    end
    m_sda_low = 0; hp(); m_scl = 1;
    repeat (H/2) @(negedge clk);
    ack = ~sda_in;
    repeat (H/2) @(negedge clk);
    m_scl = 0; @(negedge clk);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hp(); m_scl = 1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_in;
      repeat (H/2) @(negedge clk);
      m_scl = 0; @(negedge clk);
    end
    m_sda_low = give_ack; hp(); m_scl = 1; hp(); m_scl = 0; @(negedge clk); m_sda_low = 0;
  endtask

  task automatic t_reset();
    chk(sda_oe == 0, "R10 oe idle", 64'(sda_oe), 0);
    chk(cmd_valid == 0, "R10 valid idle", 64'(cmd_valid), 0);
    chk(cts == 1, "R8 cts after reset", 64'(cts), 1);
  endtask

  task automatic t_write_basic();
    bit a; int p0;
    bus_start(); send_byte(8'h22, a);
    chk(a, "R2 address A ack", 64'(a), 1);
    send_byte(8'hA1, a); chk(a, "R3 byte0 ack", 64'(a), 1);
    send_byte(8'h02, a); chk(a, "R3 byte1 ack", 64'(a), 1);
    send_byte(8'h03, a); chk(a, "R3 byte2 ack", 64'(a), 1);
    p0 = pulses;
    hp();
    chk(pulses == p0, "R1 no pulse before stop", 64'(pulses), 64'(p0));
    bus_stop();
    chk(pulses == p0 + 1, "R4 one pulse at stop", 64'(pulses), 64'(p0 + 1));
    chk(cmd_len == 3, "R4 length", 64'(cmd_len), 3);
    chk(cmd_data[23:0] == 24'h0302A1, "R3 stored bytes", 64'(cmd_data[23:0]), 64'h0302A1);
    chk(cts == 0, "R8 cts low after command", 64'(cts), 0);
  endtask

  task automatic t_read_busy();
    bit a; logic [7:0] b;
    bus_start(); send_byte(8'h23, a);
    chk(a, "R2 read address ack", 64'(a), 1);
    recv_byte(1'b0, b);
    chk(b == 8'h5A, "R5 status while busy", 64'(b), 64'h5A);
    for (int i = 0; i < 9; i++) begin
      hp(); m_scl = 1; hp();
      chk(sda_in == 1, "R7 released after nack", 64'(sda_in), 1);
      m_scl = 0; @(negedge clk);
    end
    bus_stop();
    rsp_ready = 1; @(negedge clk); rsp_ready = 0; @(negedge clk);
    chk(cts == 1, "R8 cts after rsp_ready", 64'(cts), 1);
  endtask

  task automatic t_read_long();
    bit a; logic [7:0] b, e;
    bus_start(); send_byte(8'h23, a);
    chk(a, "R2 read ack", 64'(a), 1);
    for (int i = 0; i < 18; i++) begin
      recv_byte(i != 17, b);
      e = (i == 0) ? 8'hDA : (i >= 16) ? 8'hFF : 8'(8'h30 + i);
      chk(b == e, (i >= 16) ? "R6 past end byte" : "R5 response byte", 64'(b), 64'(e));
    end
    bus_stop();
  endtask

  task automatic t_write_over();
    bit a; int p0;
    for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'hC0 + i);
    bus_start(); send_byte(8'h22, a);
    for (int i = 0; i < 10; i++) begin
      send_byte(wbuf[i], a);
      chk(a == (i < 8), "R3 ack only first eight", 64'(a), 64'(i < 8));
    end
    p0 = pulses;
    bus_stop();
    chk(pulses == p0 + 1, "R4 pulse after long write", 64'(pulses), 64'(p0 + 1));
    chk(cmd_len == 8, "R3 length capped", 64'(cmd_len), 8);
    chk(cmd_data == 64'hC7C6C5C4C3C2C1C0, "R3 extra bytes discarded", cmd_data, 64'hC7C6C5C4C3C2C1C0);
  endtask

  task automatic t_wrong_and_empty();
    bit a; int p0;
    p0 = pulses;
    bus_start(); send_byte(8'h40, a);
    chk(!a, "R2 mismatch no ack", 64'(a), 0);
    send_byte(8'h55, a);
    chk(!a, "R2 mismatch data ignored", 64'(a), 0);
    bus_stop();
    bus_start(); send_byte(8'h22, a); bus_stop();
    chk(pulses == p0, "R4 no pulse without data", 64'(pulses), 64'(p0));
  endtask

  task automatic t_alt_addr();
    bit a; int p0;
    addr_sel = 1;
    bus_start(); send_byte(8'h22, a); bus_stop();
    chk(!a, "R2 address A rejected when B selected", 64'(a), 0);
    p0 = pulses;
    bus_start(); send_byte(8'hC6, a);
    chk(a, "R2 address B ack", 64'(a), 1);
    send_byte(8'h77, a); bus_stop();
    chk(pulses == p0 + 1 && cmd_data[7:0] == 8'h77, "R4 command via address B",
        64'(cmd_data[7:0]), 64'h77);
    addr_sel = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rsp_data[i*8 +: 8] = 8'(8'h30 + i);
    rsp_data[7:0] = 8'hDA;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_basic();
    t_read_busy();
    t_read_long();
    t_write_over();
    t_wrong_and_empty();
    t_alt_addr();
    chk(viol == 0, "R9 oe changes only with clock low", 64'(viol), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule